// File: doc/BRIEF.md
# Time-Shared Gain/Offset Cache Engine for Four Level-Setting Channels

This block holds, for each of four channels, a raw level code, a gain word and an offset word. Each time a channel's raw code is written, the block computes a corrected code for that channel and keeps it in a cache. A single multiplier does this work. Pending channels go through it one at a time, lowest index first, so a burst of writes to several channels keeps the block busy for longer than a write to one channel.

The block drives an open-drain style busy request. The surrounding pad logic combines this request with the requests of other devices on a shared wired-AND line, and feeds the level of that line back in. Cached codes reach the channel outputs only for channels that were armed by a separate select strobe. The transfer happens on a load request, which is active low. A load request that arrives while the shared line is busy is remembered and applied in the first cycle in which the line is free. A load input held low permanently therefore applies each armed channel as soon as the line clears. Register writes arrive as decoded strobes from a serial front end that is not part of this block.

Top module: `dac_cache_engine`

## Requirements
- R1: A write strobe stores `wr_data` into the register of channel `wr_ch` chosen by `wr_sel`: code 0 selects the raw code, code 1 the gain and code 2 the offset. Code 3 changes nothing.
- R2: Each raw-code write queues a calculation for that channel. The cached result is ((gain + 1) × raw) / 65536 + offset − 32768, using integer division. The result is clamped to the range 0 to 65535.
- R3: `busy_drive_o` goes high in the cycle after any register write. It stays high while any channel is queued or being calculated, and it never falls in the cycle right after a write.
- R4: Queued channels are calculated one at a time, lowest index first, taking CALC_CYC cycles each. With the default CALC_CYC of 4, one raw write gives a busy pulse 5 cycles long. Raw writes to all four channels, placed every other cycle, give a pulse 17 cycles long.
- R5: A channel that is written again while it is still queued is calculated only once, using its newest register values. For example, writes to channel 0 and then twice to channel 2 give a busy pulse 9 cycles long.
- R6: The channel outputs do not change in any cycle that follows a cycle in which `busy_drive_o` is high or `busy_in` is low.
- R7: A low level on `load_n` while the line is busy is remembered. It is applied in the first cycle in which the line is free.
- R8: If `load_n` is held low, each armed channel receives its fresh cached value as soon as the line becomes free.
- R9: A load updates only the channels armed through `sel_en`/`sel_ch` since the previous load, and it then clears every arm. Unarmed channels keep their output value.
- R10: While another device holds the shared line low (`busy_in` = 0), no load is applied, even after this block has released its own request.
- R11: After reset every output code is 0 and `busy_drive_o` is low. Every gain is 65535 and every offset is 32768, so a calculation returns the raw code unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | CHW | Channel addressed by the write |
| wr_sel | input | 2 | Register choice: 0 raw, 1 gain, 2 offset, 3 none |
| wr_data | input | DW | Write data |
| sel_en | input | 1 | Arm strobe for the cached value of one channel |
| sel_ch | input | CHW | Channel to arm |
| load_n | input | 1 | Load request, active low |
| busy_in | input | 1 | Sensed level of the shared busy line (1 = free) |
| busy_drive_o | output | 1 | Request to pull the shared busy line low |
| dac_out | output | NCH*DW | Output codes, channel i in bits [i*DW +: DW] |

## Verification
Three situations are provoked on purpose. In the first, a load request arrives in the middle of a calculation. The bench pulses `load_n` while the calculation is still running, checks that the outputs hold, and then checks that the new code appears once the busy request drops. In the second, `load_n` is held low while a raw write starts a calculation, and the bench checks that the update follows the end of the pulse. In the third, the shared line is kept low by another device after this block has finished. The bench checks that the deferred load waits and then completes once the line is freed.

// File: rtl/dce_pkg.sv
package dce_pkg;
    typedef enum logic [1:0] {
        REG_RAW  = 2'd0,
        REG_GAIN = 2'd1,
        REG_OFFS = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/dce_calc.sv
module dce_calc #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] raw_i,
    input  logic [DW-1:0] gain_i,
    input  logic [DW-1:0] offs_i,
    output logic [DW-1:0] code_o
);
    localparam int PW = 2*DW + 1;
    localparam int SW = 2*DW + 2;
    localparam logic [SW-1:0] MID = SW'(1) << (DW-1);

    logic [DW:0]   gain_p1;
    logic [PW-1:0] prod;
    logic [SW-1:0] sum;

    always_comb begin
        gain_p1 = {1'b0, gain_i} + {{DW{1'b0}}, 1'b1};
        prod    = {{DW{1'b0}}, gain_p1} * {{(DW+1){1'b0}}, raw_i};
        sum     = {1'b0, prod >> DW} + {{(DW+2){1'b0}}, offs_i} - MID;
        if (sum[SW-1]) begin
            code_o = '0;
        end else if (|sum[SW-2:DW]) begin
            code_o = '1;
        end else begin
            code_o = sum[DW-1:0];
        end
    end
endmodule

// File: rtl/dce_pick.sv
module dce_pick #(
    parameter int NCH = 4,
    parameter int CHW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req_i,
    output logic           any_o,
    output logic [CHW-1:0] idx_o
);
    always_comb begin
        any_o = |req_i;
        idx_o = '0;
        for (int i = NCH-1; i >= 0; i--) begin
            if (req_i[i]) idx_o = CHW'(i);
        end
    end
endmodule

// File: rtl/dac_cache_engine.sv
module dac_cache_engine
    import dce_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int DW       = 16,
    parameter int CALC_CYC = 4,
    localparam int CHW     = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CHW-1:0]    wr_ch,
    input  logic [1:0]        wr_sel,
    input  logic [DW-1:0]     wr_data,
    input  logic              sel_en,
    input  logic [CHW-1:0]    sel_ch,
    input  logic              load_n,
    input  logic              busy_in,
    output logic              busy_drive_o,
    output logic [NCH*DW-1:0] dac_out
);
    localparam int CW = $clog2(CALC_CYC + 1);

    typedef struct packed {
        logic [NCH-1:0][DW-1:0] raw;
        logic [NCH-1:0][DW-1:0] gain;
        logic [NCH-1:0][DW-1:0] offs;
        logic [NCH-1:0][DW-1:0] cache;
        logic [NCH-1:0][DW-1:0] outc;
        logic [NCH-1:0]         queued;
        logic [NCH-1:0]         armed;
        logic                   running;
        logic [CHW-1:0]         cur;
        logic [CW-1:0]          cnt;
        logic                   load_held;
        logic                   drive;
    } state_t;

    function automatic state_t reset_state();
        state_t s;
        s = '0;
        for (int i = 0; i < NCH; i++) begin
            s.gain[i] = '1;
            s.offs[i] = DW'(1) << (DW-1);
        end
        return s;
    endfunction

    state_t st_d, st_q;

    logic          pick_any;
    logic [CHW-1:0] pick_idx;
    logic [DW-1:0] calc_code;

    dce_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
        .req_i (st_q.queued),
        .any_o (pick_any),
        .idx_o (pick_idx)
    );

    dce_calc #(.DW(DW)) u_calc (
        .raw_i  (st_q.raw[st_q.cur]),
        .gain_i (st_q.gain[st_q.cur]),
        .offs_i (st_q.offs[st_q.cur]),
        .code_o (calc_code)
    );

    logic finish_d;
    logic load_req_d;
    logic apply_d;

    always_comb begin
        st_d = st_q;

        // sequential calculation on the shared multiplier
        finish_d = st_q.running && (st_q.cnt == '0);
        if (finish_d) begin
            st_d.cache[st_q.cur] = calc_code;
            st_d.running         = 1'b0;
        end else if (st_q.running) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
        if ((!st_q.running || finish_d) && pick_any) begin
            st_d.running          = 1'b1;
            st_d.cur              = pick_idx;
            st_d.cnt              = CW'(CALC_CYC - 1);
            st_d.queued[pick_idx] = 1'b0;
        end

        // register writes (a raw write queues its channel)
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                REG_RAW: begin
                    st_d.raw[wr_ch]    = wr_data;
                    st_d.queued[wr_ch] = 1'b1;
                end
                REG_GAIN: st_d.gain[wr_ch] = wr_data;
                REG_OFFS: st_d.offs[wr_ch] = wr_data;
                default:  ;
            endcase
        end

        // load latching and output transfer
        load_req_d     = st_q.load_held || !load_n;
        apply_d        = load_req_d && !st_q.drive && busy_in;
        st_d.load_held = load_req_d && !apply_d;
        if (apply_d) begin
            for (int i = 0; i < NCH; i++) begin
                if (st_q.armed[i]) st_d.outc[i] = st_q.cache[i];
            end
            st_d.armed = '0;
        end
        if (sel_en) st_d.armed[sel_ch] = 1'b1;

        st_d.drive = wr_en || (|st_d.queued) || st_d.running;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= reset_state();
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_drive_o = st_q.drive;

    for (genvar g = 0; g < NCH; g++) begin : g_out
        assign dac_out[g*DW +: DW] = st_q.outc[g];
    end
endmodule

// File: rtl/dce_checker.sv
module dce_checker #(
    parameter int NCH = 4,
    parameter int DW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              busy_in,
    input logic              busy_drive_o,
    input logic [NCH*DW-1:0] dac_out
);
    assert_write_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> busy_drive_o);

    assert_no_fall_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_drive_o) |-> !$past(wr_en));

    // covers R10 as well through busy_in
    assert_hold_while_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_drive_o || !busy_in) |=> $stable(dac_out));

    assert_reset_state_R11: assert property (@(posedge clk)
        !rst_n |=> (dac_out == '0 && !busy_drive_o));
endmodule

bind dac_cache_engine dce_checker #(.NCH(NCH), .DW(DW)) u_dce_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .busy_in      (busy_in),
    .busy_drive_o (busy_drive_o),
    .dac_out      (dac_out)
);

// File: tb/dac_cache_engine_test.sv
module dac_cache_engine_test;
    localparam int NCH = 4;
    localparam int DW  = 16;
    localparam int CC  = 4;
    localparam int NV  = 8;
    // each vector: {raw, gain, offset}; channel = index mod 4
    localparam logic [47:0] VEC [NV] = '{
        {16'h4000, 16'hFFFF, 16'h8000},
        {16'h8000, 16'h7FFF, 16'h8000},
        {16'hFFFF, 16'hFFFF, 16'hFFFF},
        {16'h0100, 16'h0000, 16'h0000},
        {16'h1234, 16'h3FFF, 16'h9000},
        {16'hABCD, 16'hC000, 16'h7000},
        {16'h0010, 16'h0000, 16'h8005},
        {16'h8000, 16'hFFFF, 16'h0000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_ch = '0;
    logic [1:0]        wr_sel = '0;
    logic [DW-1:0]     wr_data = '0;
    logic              sel_en = 1'b0;
    logic [1:0]        sel_ch = '0;
    logic              load_n = 1'b1;
    logic              others_free = 1'b1;
    logic              busy_in;
    logic              busy_drive_o;
    logic [NCH*DW-1:0] dac_out;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int bcnt  = 0;
    int exp_dac [NCH];

    assign busy_in = !busy_drive_o && others_free;

    always #5 clk = ~clk;

    dac_cache_engine #(.NCH(NCH), .DW(DW), .CALC_CYC(CC)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch), .wr_sel(wr_sel),
        .wr_data(wr_data), .sel_en(sel_en), .sel_ch(sel_ch), .load_n(load_n),
        .busy_in(busy_in), .busy_drive_o(busy_drive_o), .dac_out(dac_out)
    );

    always @(negedge clk) if (busy_drive_o) bcnt++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired (all requirements) act=%0d exp=<100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int model(int raw, int gain, int offs);
        longint p;
        int v;
        p = (longint'(gain) + 1) * longint'(raw);
        v = int'(p / 65536) + offs - 32768;
        if (v < 0) v = 0;
        if (v > 65535) v = 65535;
        return v;
    endfunction

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wr(int ch, int sel, int data);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 2'(ch); wr_sel = 2'(sel); wr_data = 16'(data);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic arm(int ch);
        @(negedge clk);
        sel_en = 1'b1; sel_ch = 2'(ch);
        @(negedge clk);
        sel_en = 1'b0;
    endtask

    task automatic pulse_load();
        @(negedge clk);
        load_n = 1'b0;
        @(negedge clk);
        load_n = 1'b1;
    endtask

    task automatic wait_idle();
        while (busy_drive_o || !busy_in) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic int outc(int ch);
        return int'(dac_out[ch*DW +: DW]);
    endfunction

    task automatic chk_all(string req);
        for (int i = 0; i < NCH; i++) chk(req, outc(i), exp_dac[i]);
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) exp_dac[i] = 0;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 drive", int'(busy_drive_o), 0);
        chk("R11 out", int'(dac_out[DW-1:0]), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R11: code 3 writes nothing; defaults give identity
        wr(3, 3, 16'h1234);
        wr(3, 0, 16'h4000);
        chk("R3 busy after write", int'(busy_drive_o), 1);
        arm(3);
        pulse_load();
        wait_idle();
        exp_dac[3] = 16'h4000;
        chk("R1 R11 identity", outc(3), exp_dac[3]);

        // R2: vector table
        for (int i = 0; i < NV; i++) begin
            int ch;
            ch = i % NCH;
            wr(ch, 1, int'(VEC[i][31:16]));
            wr(ch, 2, int'(VEC[i][15:0]));
            wr(ch, 0, int'(VEC[i][47:32]));
            arm(ch);
            pulse_load();
            wait_idle();
            exp_dac[ch] = model(int'(VEC[i][47:32]), int'(VEC[i][31:16]), int'(VEC[i][15:0]));
            chk("R2 calc", outc(ch), exp_dac[ch]);
        end

        // R4: busy length, one channel then four channels
        bcnt = 0;
        wr(0, 0, 16'h0001);
        wait_idle();
        chk("R4 one channel", bcnt, CC + 1);
        bcnt = 0;
        for (int i = 0; i < NCH; i++) wr(i, 0, 16'h0100 * (i + 1));
        wait_idle();
        chk("R4 four channels", bcnt, 4 * CC + 1);
        chk_all("R9 no arm no change");

        // R5: requeued channel computed once with newest value
        wr(2, 1, 16'hFFFF);
        wr(2, 2, 16'h8000);
        wait_idle();
        bcnt = 0;
        wr(0, 0, 16'h0002);
        wr(2, 0, 16'h1111);
        wr(2, 0, 16'h2468);
        wait_idle();
        chk("R5 single compute", bcnt, 2 * CC + 1);
        arm(2);
        pulse_load();
        wait_idle();
        exp_dac[2] = 16'h2468;
        chk("R5 newest value", outc(2), exp_dac[2]);

        // R9: only armed channel updates
        wr(0, 1, 16'hFFFF); wr(0, 2, 16'h8000);
        wr(1, 1, 16'hFFFF); wr(1, 2, 16'h8000);
        wr(0, 0, 16'h1111);
        wr(1, 0, 16'h2222);
        wait_idle();
        arm(1);
        pulse_load();
        wait_idle();
        exp_dac[1] = 16'h2222;
        chk("R9 armed", outc(1), exp_dac[1]);
        chk("R9 unarmed", outc(0), exp_dac[0]);
        pulse_load();
        wait_idle();
        chk("R9 arm cleared", outc(0), exp_dac[0]);

        // R7 / R6: load during busy deferred
        wr(3, 1, 16'hFFFF); wr(3, 2, 16'h8000);
        wait_idle();
        wr(3, 0, 16'h0777);
        arm(3);
        pulse_load();
        chk("R6 still busy", int'(busy_drive_o), 1);
        chk("R6 held while busy", outc(3), exp_dac[3]);
        wait_idle();
        exp_dac[3] = 16'h0777;
        chk("R7 deferred load", outc(3), exp_dac[3]);

        // R8: load held low permanently
        @(negedge clk);
        load_n = 1'b0;
        wr(0, 0, 16'h0ABC);
        arm(0);
        wait_idle();
        exp_dac[0] = 16'h0ABC;
        chk("R8 held load", outc(0), exp_dac[0]);
        @(negedge clk);
        load_n = 1'b1;

        // R10: line held by another device
        others_free = 1'b0;
        wr(1, 0, 16'h3333);
        arm(1);
        pulse_load();
        while (busy_drive_o) @(negedge clk);
        repeat (4) @(negedge clk);
        chk("R10 held by line", outc(1), exp_dac[1]);
        others_free = 1'b1;
        repeat (2) @(negedge clk);
        exp_dac[1] = 16'h3333;
        chk("R10 after release", outc(1), exp_dac[1]);
        chk_all("R6 final outputs");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule